// File: doc/BRIEF.md
# Line Buffer Read Address Generator

This block steps through the DWORD read addresses of a horizontal video line buffer, one display line at a time. A start-of-line pulse loads the line setup: a first address, an 8-bit DWORD count with a separate extension bit worth 256 DWORDs, a 4:2:0 mode bit and a horizontal filter enable. After that pulse the block presents one address per accepted beat until the last DWORD of the line. A first address above zero clips the left edge of the video window, because the first source DWORDs of the line are never read.

The address leaves on a valid/ready stream. The address is held, and `rd_valid` stays high, until the consumer takes the beat with `rd_ready` high at a clock edge. The consumer applies no other back-pressure. `rd_eol` marks the beat that carries the last address of the line. `interp_sel` tells the downstream scaler to interpolate (1) or repeat pixels (0) for the whole line. `align_warn` reports that a misaligned first address was corrected in 4:2:0 mode. The block latches all line setup at the start-of-line pulse. Changes to the setup pins in the middle of a line therefore do nothing until the next pulse.

Top module: `linebuf_rdaddr`

## Requirements
- R1: After reset, `rd_valid`, `rd_eol`, `interp_sel` and `align_warn` are 0 and `rd_addr` is 0.
- R2: `sol` high at a clock edge loads `rd_addr` with the first address from `init_addr`. If the line is not empty, `rd_valid` is 1 after that same edge.
- R3: The line length is `line_size` + 256 × `size_ext` DWORDs. `rd_eol` is 1 exactly while `rd_valid` is 1 and `rd_addr` equals length − 1.
- R4: Each edge with `rd_valid` and `rd_ready` both high advances `rd_addr` by one, unless that beat carries `rd_eol`. While `rd_ready` is low, `rd_addr` and `rd_valid` hold.
- R5: After the beat that carries `rd_eol` is taken, `rd_valid` falls. Later `rd_ready` pulses are ignored, and `rd_addr` holds until the next `sol`.
- R6: When `mode_420` is 1 at `sol`, the first address has bits [1:0] forced to 0. `align_warn` is then 1 for the line if those bits of `init_addr` were nonzero. When `mode_420` is 0, `init_addr` is used unchanged and `align_warn` is 0.
- R7: A line of length zero (`line_size` = 0 with `size_ext` = 0) produces no valid address. The same holds when the first address is not below the length.
- R8: `interp_sel` takes the value of `hfilt_en` at `sol` and keeps it for the line. Changes to `hfilt_en`, `line_size` or `size_ext` during a line have no effect on it.
- R9: `sol` restarts the line even in the middle of a line. It takes priority over a beat accepted at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sol | input | 1 | Start-of-line pulse |
| init_addr | input | SIZE_W+1 | First DWORD address of the line (left clip) |
| line_size | input | SIZE_W | Line length in DWORDs, low part |
| size_ext | input | 1 | Adds 2^SIZE_W DWORDs to the length |
| mode_420 | input | 1 | 4:2:0 mode, forces first-address alignment |
| hfilt_en | input | 1 | Horizontal filter: 1 interpolate, 0 repeat |
| rd_addr | output | SIZE_W+1 | Read address of the current beat |
| rd_valid | output | 1 | Read address is valid |
| rd_ready | input | 1 | Consumer takes the beat (advance strobe) |
| rd_eol | output | 1 | Current beat is the last of the line |
| interp_sel | output | 1 | Scaler select latched at line start |
| align_warn | output | 1 | Misaligned first address was corrected |

## Verification
The bench covers these corner cases:
- **Extension bit.** Lines that use the extension bit must stop exactly at DWORD 255 or 510. A design that ignores the extension bit or drops its weight would end the line early or never raise `rd_eol`.
- **Misaligned 4:2:0 address.** A misaligned first address in 4:2:0 mode checks both the cleared low bits and the warning flag.
- **Empty and overclipped lines.** A zero-length line and a line whose first address lies past its end must stay silent. A design that treats length zero as 256 or wraps past the end would emit addresses here.
- **Late and early control.** The bench sends `rd_ready` pulses after the last beat, setup changes in the middle of a line, and a `sol` that coincides with an accepted beat. A counter that runs past its last address, reads live setup pins, or lets the beat win over the restart would each show a wrong address at the port.

// File: rtl/linebuf_rdaddr_pkg.sv
package linebuf_rdaddr_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } lbra_state_e;
endpackage

// File: rtl/linebuf_rdaddr_cfg.sv
// Combinational decode of line setup: length, aligned start, empty test.
module linebuf_rdaddr_cfg #(
  parameter int SIZE_W     = 8,
  parameter int ALIGN_BITS = 2,
  localparam int ADDR_W    = SIZE_W + 1
) (
  input  logic [ADDR_W-1:0] init_addr,
  input  logic [SIZE_W-1:0] line_size,
  input  logic              size_ext,
  input  logic              mode_420,
  output logic [ADDR_W-1:0] start_addr,
  output logic [ADDR_W-1:0] last_addr,
  output logic              line_empty,
  output logic              misaligned
);
  logic [ADDR_W-1:0] len;

  assign len       = {size_ext, line_size};
  assign last_addr = len - ADDR_W'(1);

  generate
    if (ALIGN_BITS > 0) begin : g_align
      assign start_addr = mode_420 ? {init_addr[ADDR_W-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}}
                                   : init_addr;
      assign misaligned = mode_420 && (|init_addr[ALIGN_BITS-1:0]);
    end else begin : g_noalign
      logic unused_mode;
      assign unused_mode = mode_420;
      assign start_addr  = init_addr;
      assign misaligned  = 1'b0;
    end
  endgenerate

  assign line_empty = (start_addr >= len);
endmodule

// File: rtl/linebuf_rdaddr_seq.sv
// Line state, address counter and per-line latched controls.
module linebuf_rdaddr_seq
  import linebuf_rdaddr_pkg::*;
#(
  parameter int SIZE_W  = 8,
  localparam int ADDR_W = SIZE_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sol,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [ADDR_W-1:0] last_addr,
  input  logic              line_empty,
  input  logic              misaligned,
  input  logic              hfilt_en,
  input  logic              rd_ready,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              rd_valid,
  output logic              rd_eol,
  output logic              interp_sel,
  output logic              align_warn
);
  lbra_state_e       state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] last_q;
  logic              interp_q;
  logic              warn_q;
  logic              at_last;
  logic              take;

  assign at_last = (addr_q == last_q);
  assign take    = (state_q == ST_RUN) && rd_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      addr_q   <= '0;
      last_q   <= '0;
      interp_q <= 1'b0;
      warn_q   <= 1'b0;
    end else if (sol) begin
      state_q  <= line_empty ? ST_IDLE : ST_RUN;
      addr_q   <= start_addr;
      last_q   <= last_addr;
      interp_q <= hfilt_en;
      warn_q   <= misaligned;
    end else if (take) begin
      if (at_last) begin
        state_q <= ST_IDLE;
      end else begin
        addr_q <= addr_q + ADDR_W'(1);
      end
    end
  end

  assign rd_addr    = addr_q;
  assign rd_valid   = (state_q == ST_RUN);
  assign rd_eol     = rd_valid && at_last;
  assign interp_sel = interp_q;
  assign align_warn = warn_q;
endmodule

// File: rtl/linebuf_rdaddr.sv
module linebuf_rdaddr #(
  parameter int SIZE_W     = 8,
  parameter int ALIGN_BITS = 2,
  localparam int ADDR_W    = SIZE_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sol,
  input  logic [ADDR_W-1:0] init_addr,
  input  logic [SIZE_W-1:0] line_size,
  input  logic              size_ext,
  input  logic              mode_420,
  input  logic              hfilt_en,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic              rd_eol,
  output logic              interp_sel,
  output logic              align_warn
);
  logic [ADDR_W-1:0] start_addr;
  logic [ADDR_W-1:0] last_addr;
  logic              line_empty;
  logic              misaligned;

  linebuf_rdaddr_cfg #(.SIZE_W(SIZE_W), .ALIGN_BITS(ALIGN_BITS)) u_cfg (
    .init_addr (init_addr),
    .line_size (line_size),
    .size_ext  (size_ext),
    .mode_420  (mode_420),
    .start_addr(start_addr),
    .last_addr (last_addr),
    .line_empty(line_empty),
    .misaligned(misaligned)
  );

  linebuf_rdaddr_seq #(.SIZE_W(SIZE_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .sol       (sol),
    .start_addr(start_addr),
    .last_addr (last_addr),
    .line_empty(line_empty),
    .misaligned(misaligned),
    .hfilt_en  (hfilt_en),
    .rd_ready  (rd_ready),
    .rd_addr   (rd_addr),
    .rd_valid  (rd_valid),
    .rd_eol    (rd_eol),
    .interp_sel(interp_sel),
    .align_warn(align_warn)
  );
endmodule

// File: rtl/linebuf_rdaddr_chk.sv
module linebuf_rdaddr_chk #(
  parameter int SIZE_W  = 8,
  localparam int ADDR_W = SIZE_W + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sol,
  input logic [ADDR_W-1:0] init_addr,
  input logic [SIZE_W-1:0] line_size,
  input logic              size_ext,
  input logic              mode_420,
  input logic              hfilt_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              rd_valid,
  input logic              rd_ready,
  input logic              rd_eol,
  input logic              interp_sel,
  input logic              align_warn
);
  // R1
  a_r1_reset_idle: assert property (@(posedge clk)
    !rst_n |=> !rd_valid && !align_warn && !interp_sel);

  // R2 / R6
  a_r2_preload: assert property (@(posedge clk) disable iff (!rst_n)
    sol |=> rd_addr == ($past(mode_420) ? ($past(init_addr) & ~ADDR_W'(3)) : $past(init_addr)));

  a_r6_align: assert property (@(posedge clk) disable iff (!rst_n)
    sol && mode_420 |=> rd_addr[1:0] == 2'b00);

  // R3
  a_r3_eol_valid: assert property (@(posedge clk) disable iff (!rst_n)
    rd_eol |-> rd_valid);

  // R4
  a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && rd_ready && !rd_eol && !sol |=> rd_valid && rd_addr == $past(rd_addr) + ADDR_W'(1));

  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready && !sol |=> rd_valid && $stable(rd_addr));

  // R5
  a_r5_end: assert property (@(posedge clk) disable iff (!rst_n)
    rd_eol && rd_ready && !sol |=> !rd_valid);

  a_r5_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid && !sol |=> !rd_valid && $stable(rd_addr));

  // R7
  a_r7_empty: assert property (@(posedge clk) disable iff (!rst_n)
    sol && line_size == '0 && !size_ext |=> !rd_valid);

  // R8
  a_r8_interp: assert property (@(posedge clk) disable iff (!rst_n)
    sol |=> interp_sel == $past(hfilt_en));

  a_r8_interp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !sol |=> $stable(interp_sel) && $stable(align_warn));
endmodule

bind linebuf_rdaddr linebuf_rdaddr_chk #(.SIZE_W(SIZE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sol       (sol),
  .init_addr (init_addr),
  .line_size (line_size),
  .size_ext  (size_ext),
  .mode_420  (mode_420),
  .hfilt_en  (hfilt_en),
  .rd_addr   (rd_addr),
  .rd_valid  (rd_valid),
  .rd_ready  (rd_ready),
  .rd_eol    (rd_eol),
  .interp_sel(interp_sel),
  .align_warn(align_warn)
);

// File: tb/linebuf_rdaddr_tb.sv
`timescale 1ns/1ps
module linebuf_rdaddr_tb;
  localparam int SIZE_W = 8;
  localparam int ADDR_W = SIZE_W + 1;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              sol;
  logic [ADDR_W-1:0] init_addr;
  logic [SIZE_W-1:0] line_size;
  logic              size_ext;
  logic              mode_420;
  logic              hfilt_en;
  logic [ADDR_W-1:0] rd_addr;
  logic              rd_valid;
  logic              rd_ready;
  logic              rd_eol;
  logic              interp_sel;
  logic              align_warn;

  int total = 0;
  int bad   = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  linebuf_rdaddr #(.SIZE_W(SIZE_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .sol(sol), .init_addr(init_addr),
    .line_size(line_size), .size_ext(size_ext), .mode_420(mode_420),
    .hfilt_en(hfilt_en), .rd_addr(rd_addr), .rd_valid(rd_valid),
    .rd_ready(rd_ready), .rd_eol(rd_eol), .interp_sel(interp_sel),
    .align_warn(align_warn)
  );

  // Vector: init(9) size(8) ext(1) m420(1) hf(1) exp_start(9) exp_n(10) exp_warn(1)
  localparam int NV = 8;
  localparam logic [39:0] VEC [NV] = '{
    {9'd0,   8'd4,   1'b0, 1'b0, 1'b0, 9'd0,   10'd4, 1'b0},  // R3 basic
    {9'd3,   8'd8,   1'b0, 1'b1, 1'b1, 9'd0,   10'd8, 1'b1},  // R6 fix + warn
    {9'd5,   8'd8,   1'b0, 1'b0, 1'b1, 9'd5,   10'd3, 1'b0},  // R2 clip
    {9'd250, 8'd0,   1'b1, 1'b0, 1'b0, 9'd250, 10'd6, 1'b0},  // R3 ext only
    {9'd0,   8'd0,   1'b0, 1'b0, 1'b1, 9'd0,   10'd0, 1'b0},  // R7 zero length
    {9'd6,   8'd5,   1'b0, 1'b0, 1'b0, 9'd6,   10'd0, 1'b0},  // R7 overclip
    {9'd510, 8'd255, 1'b1, 1'b0, 1'b1, 9'd510, 10'd1, 1'b0},  // R3 max length
    {9'd511, 8'd255, 1'b1, 1'b1, 1'b0, 9'd508, 10'd3, 1'b1}   // R6 high end
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic start_line(input logic [ADDR_W-1:0] ia, input logic [SIZE_W-1:0] ls,
                            input logic ex, input logic m4, input logic hf, input logic rdy);
    @(negedge clk);
    sol = 1'b1; init_addr = ia; line_size = ls; size_ext = ex;
    mode_420 = m4; hfilt_en = hf; rd_ready = rdy;
    @(negedge clk);
    sol = 1'b0;
  endtask

  initial begin
    while (cycles < 100000) begin
      @(posedge clk);
      cycles++;
    end
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; sol = 1'b0; init_addr = '0; line_size = '0; size_ext = 1'b0;
    mode_420 = 1'b0; hfilt_en = 1'b0; rd_ready = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 valid", rd_valid, 0);
    chk("R1 addr", rd_addr, 0);
    chk("R1 eol", rd_eol, 0);
    chk("R1 warn", align_warn, 0);
    chk("R1 interp", interp_sel, 0);
    rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      logic [39:0] e;
      int n;
      e = VEC[v];
      n = int'(e[10:1]);
      start_line(e[39:31], e[30:23], e[22], e[21], e[20], 1'b0);
      chk("R2 valid after sol", rd_valid, (n > 0) ? 1 : 0);
      chk("R6 warn", align_warn, e[0]);
      chk("R8 interp", interp_sel, e[20]);
      if (n > 0) chk("R2 start addr", rd_addr, e[19:11]);
      rd_ready = 1'b1;
      for (int i = 0; i < n; i++) begin
        chk("R4 addr", rd_addr, e[19:11] + i);
        chk("R3 eol", rd_eol, (i == n - 1) ? 1 : 0);
        @(negedge clk);
      end
      chk("R5 valid drops", rd_valid, 0);
      repeat (3) @(negedge clk);
      chk("R5 idle valid", rd_valid, 0);
      if (n > 0) chk("R5 addr holds", rd_addr, e[19:11] + n - 1);
      rd_ready = 1'b0;
    end

    // R4 back-pressure
    start_line(9'd10, 8'd20, 1'b0, 1'b0, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    chk("R4 hold addr", rd_addr, 10);
    chk("R4 hold valid", rd_valid, 1);
    rd_ready = 1'b1;
    @(negedge clk);
    chk("R4 step", rd_addr, 11);

    // R9 sol with accepted beat: restart wins
    start_line(9'd3, 8'd20, 1'b0, 1'b0, 1'b1, 1'b1);
    chk("R9 restart addr", rd_addr, 3);
    @(negedge clk);
    chk("R9 continues", rd_addr, 4);
    rd_ready = 1'b0;

    // R8 setup change mid-line is ignored
    start_line(9'd0, 8'd8, 1'b0, 1'b0, 1'b1, 1'b1);
    @(negedge clk);
    @(negedge clk);
    hfilt_en = 1'b0; line_size = 8'd2; size_ext = 1'b1;
    for (int i = 2; i < 8; i++) begin
      chk("R8 interp held", interp_sel, 1);
      chk("R8 addr", rd_addr, i);
      chk("R8 eol", rd_eol, (i == 7) ? 1 : 0);
      @(negedge clk);
    end
    chk("R8 line ends", rd_valid, 0);
    rd_ready = 1'b0;

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule